// File: doc/BRIEF.md
# Scan Chain Refresh Controller

This block services a long serial chain of identical per-design scan cells. Each cell holds eight bits. On every refresh it writes eight input values into one chosen cell and reads back the eight output values that cell's design produced. The chain has one clock, one serial data line, a capture strobe and a latch strobe. The controller runs its refresh loop on its own from the moment reset is released, and it repeats that loop forever.

A refresh has four parts: a capture beat, a full-length shift of the chain, a latch pulse, and a completion cycle. In the capture beat every cell loads its design's outputs into its shift stage. During the shift the input byte is fed in so that it ends up in the target cell, and the target's captured byte is picked off the chain tail as it passes. The latch pulse then moves every shift stage into its design inputs. On the completion cycle, `refresh_done` pulses and `dout` takes the new byte.

The completion strobe has no back-pressure. A refresh cannot stall, so `refresh_done` marks `dout` as valid for exactly one cycle, and `dout` then holds until the next strobe.

A two-bit drive mode can hand the four chain control lines to external pins or to a probe port instead of the internal sequencer. A small divider, synchronised to refreshes, can produce a slow square wave. When enabled, that wave replaces input bit 0 of the written byte.

Top module: `scanchain_refresh_ctrl`

## Requirements
- R1: Timing of a refresh, with L = NUM_DESIGNS*DW and period 2L+4 cycles, counted from the first clock after reset:
  - Cycles 0 and 1: `chain_capture` is high, and `chain_clk` is high in cycle 1 only.
  - Shift step j (1..L): `chain_clk` is low in cycle 2j and high in cycle 2j+1.
  - Cycle 2L+2: `chain_latch` is high, with the clock and capture low.
  - Cycle 2L+3: `refresh_done` is high.
- R2: Chain positions are counted from the tail, and position 0 leaves the chain first. The bit sent in shift step j ends at position j-1. Input bit b is written to position target*DW+b, and every other position receives 0. After the latch pulse, the target cell's design inputs equal the written byte and all other cells hold 0.
- R3: Bit b of `dout` is the target cell's captured output bit b. It is read from `chain_tail` just before the clock edge of shift step target*DW+b+1.
- R4: `refresh_done` is high for exactly one cycle per refresh. `dout` changes only in that cycle and holds its value at all other times.
- R5: `target_idx` and `din` are sampled once, in the first cycle of a refresh. Changing them later in the refresh has no effect on that refresh.
- R6: When `target_idx` is NUM_DESIGNS or larger, `dout` becomes 0 and every cell is written with 0.
- R7: `drive_mode` selects who drives the four chain control outputs, combinationally:
  - 00: the `ext_*` inputs.
  - 01: the `probe_*` inputs.
  - 10 or 11: the internal sequencer.
- R8: On the cycle `div_enable` rises, the divider value N is captured from `din`.
- R9: While `div_enable` is high, `tick_clk` toggles once every N+1 completed refreshes. While it is low, `tick_clk` is 0.
- R10: While `div_enable` is high, bit 0 of the written byte is the `tick_clk` value at sampling time instead of `din[0]`.
- R11: While reset is active, all outputs are 0, and they remain 0 until the first clock edge after its release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| target_idx | input | SEL_W | Index of the cell to refresh |
| din | input | DW | Byte to write; also the divider value on enable |
| drive_mode | input | 2 | Chain driver selection |
| div_enable | input | 1 | Enables the slow divider and captures N |
| ext_clk | input | 1 | External chain clock |
| ext_data | input | 1 | External chain data |
| ext_capture | input | 1 | External capture strobe |
| ext_latch | input | 1 | External latch strobe |
| probe_clk | input | 1 | Probe-port chain clock |
| probe_data | input | 1 | Probe-port chain data |
| probe_capture | input | 1 | Probe-port capture strobe |
| probe_latch | input | 1 | Probe-port latch strobe |
| chain_tail | input | 1 | Serial data returning from the chain tail |
| chain_clk | output | 1 | Chain scan clock |
| chain_data | output | 1 | Chain serial data |
| chain_capture | output | 1 | Chain capture strobe |
| chain_latch | output | 1 | Chain latch strobe |
| dout | output | DW | Byte read from the target cell |
| refresh_done | output | 1 | One-cycle refresh-complete strobe |
| tick_clk | output | 1 | Slow divided clock |

## Verification
The bench builds the controller with NUM_DESIGNS = 4 and DW = 8, which gives a 32-bit chain and a 68-cycle refresh. At that size every valid index can be written and read back within a short run, and so can two out-of-range indices. The bench also covers divider settings of 0 and 2 over many refreshes. The default of 500 cells would make each refresh about 8000 cycles long, so only a handful of refreshes could be observed at that size.

// File: rtl/scr_pkg.sv
package scr_pkg;

  typedef enum logic [1:0] {
    DRV_EXT   = 2'b00,
    DRV_PROBE = 2'b01,
    DRV_INT_A = 2'b10,
    DRV_INT_B = 2'b11
  } drive_mode_e;

  typedef struct packed {
    logic clk;
    logic data;
    logic capture;
    logic latch;
  } chain_ctl_t;

endpackage

// File: rtl/scr_sequencer.sv
module scr_sequencer
  import scr_pkg::*;
#(
  parameter int NUM_DESIGNS = 500,
  parameter int DW          = 8,
  parameter int SEL_W       = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] target_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic             tail_i,
  output chain_ctl_t       ctl_o,
  output logic [DW-1:0]    dout_o,
  output logic             done_o,
  output logic             end_o
);

  localparam int CHAIN_LEN = NUM_DESIGNS * DW;
  localparam int PERIOD    = 2 * CHAIN_LEN + 4;
  localparam int CW        = $clog2(PERIOD);
  localparam int LW        = $clog2(DW);
  localparam int PW        = ((CW > SEL_W + LW) ? CW : SEL_W + LW) + 1;

  logic [CW-1:0]    cyc;
  logic [SEL_W-1:0] sel_q;
  logic [DW-1:0]    wbuf_q, rbuf_q;
  logic             is_shift, hit;
  logic [PW-1:0]    pos, base;
  logic [LW-1:0]    bidx;
  chain_ctl_t       nxt;

  always_comb begin
    is_shift = (cyc >= CW'(2)) && (cyc < CW'(2 * CHAIN_LEN + 2));
    pos      = PW'((cyc - CW'(2)) >> 1);
    base     = PW'(sel_q) * PW'(DW);
    hit      = is_shift && (pos >= base) && (pos < base + PW'(DW));
    bidx     = LW'(pos - base);
    end_o    = (cyc == CW'(PERIOD - 1));
    nxt.clk     = cyc[0] && (cyc < CW'(2 * CHAIN_LEN + 2));
    nxt.data    = hit ? wbuf_q[bidx] : 1'b0;
    nxt.capture = (cyc < CW'(2));
    nxt.latch   = (cyc == CW'(2 * CHAIN_LEN + 2));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc    <= '0;
      ctl_o  <= '0;
      sel_q  <= '0;
      wbuf_q <= '0;
      rbuf_q <= '0;
      dout_o <= '0;
      done_o <= 1'b0;
    end else begin
      cyc    <= end_o ? '0 : cyc + CW'(1);
      ctl_o  <= nxt;
      done_o <= end_o;
      if (cyc == '0) begin
        sel_q  <= target_i;
        wbuf_q <= wdata_i;
        rbuf_q <= '0;
      end
      if (hit && cyc[0]) rbuf_q[bidx] <= tail_i;
      if (end_o) dout_o <= rbuf_q;
    end
  end

  assert_latch_clock_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_o.latch |-> (!ctl_o.clk && !ctl_o.capture));

  assert_capture_edge_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctl_o.capture) |-> $past(ctl_o.clk));

  assert_done_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_dout_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(dout_o));

endmodule

// File: rtl/scr_tick_div.sv
module scr_tick_div #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  logic [DW-1:0] din_i,
  input  logic          end_i,
  output logic          tick_o
);

  logic          en_q;
  logic [DW-1:0] div_q, cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      div_q  <= '0;
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else begin
      en_q <= en_i;
      if (!en_i) begin
        cnt_q  <= '0;
        tick_o <= 1'b0;
      end else if (!en_q) begin
        div_q <= din_i;
        cnt_q <= '0;
      end else if (end_i) begin
        if (cnt_q == div_q) begin
          cnt_q  <= '0;
          tick_o <= ~tick_o;
        end else begin
          cnt_q <= cnt_q + DW'(1);
        end
      end
    end
  end

  assert_tick_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> !tick_o);

  assert_tick_on_refresh_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(tick_o) && $past(en_i)) |-> $past(end_i));

  assert_count_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |-> (cnt_q <= div_q));

endmodule

// File: rtl/scr_drive_mux.sv
module scr_drive_mux
  import scr_pkg::*;
(
  input  logic [1:0] mode_i,
  input  chain_ctl_t ext_i,
  input  chain_ctl_t probe_i,
  input  chain_ctl_t int_i,
  output chain_ctl_t ctl_o
);

  always_comb begin
    case (drive_mode_e'(mode_i))
      DRV_EXT:   ctl_o = ext_i;
      DRV_PROBE: ctl_o = probe_i;
      default:   ctl_o = int_i;
    endcase
  end

endmodule

// File: rtl/scanchain_refresh_ctrl.sv
module scanchain_refresh_ctrl
  import scr_pkg::*;
#(
  parameter int NUM_DESIGNS = 500,
  parameter int DW          = 8,
  parameter int SEL_W       = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] target_idx,
  input  logic [DW-1:0]    din,
  input  logic [1:0]       drive_mode,
  input  logic             div_enable,
  input  logic             ext_clk,
  input  logic             ext_data,
  input  logic             ext_capture,
  input  logic             ext_latch,
  input  logic             probe_clk,
  input  logic             probe_data,
  input  logic             probe_capture,
  input  logic             probe_latch,
  input  logic             chain_tail,
  output logic             chain_clk,
  output logic             chain_data,
  output logic             chain_capture,
  output logic             chain_latch,
  output logic [DW-1:0]    dout,
  output logic             refresh_done,
  output logic             tick_clk
);

  chain_ctl_t    int_ctl, ext_ctl, probe_ctl, out_ctl;
  logic [DW-1:0] wdata;
  logic          refresh_end;

  assign wdata     = {din[DW-1:1], div_enable ? tick_clk : din[0]};
  assign ext_ctl   = '{clk: ext_clk, data: ext_data, capture: ext_capture, latch: ext_latch};
  assign probe_ctl = '{clk: probe_clk, data: probe_data, capture: probe_capture, latch: probe_latch};

  scr_sequencer #(.NUM_DESIGNS(NUM_DESIGNS), .DW(DW), .SEL_W(SEL_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .target_i (target_idx),
    .wdata_i  (wdata),
    .tail_i   (chain_tail),
    .ctl_o    (int_ctl),
    .dout_o   (dout),
    .done_o   (refresh_done),
    .end_o    (refresh_end)
  );

  scr_tick_div #(.DW(DW)) u_div (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_i   (div_enable),
    .din_i  (din),
    .end_i  (refresh_end),
    .tick_o (tick_clk)
  );

  scr_drive_mux u_mux (
    .mode_i  (drive_mode),
    .ext_i   (ext_ctl),
    .probe_i (probe_ctl),
    .int_i   (int_ctl),
    .ctl_o   (out_ctl)
  );

  assign chain_clk     = out_ctl.clk;
  assign chain_data    = out_ctl.data;
  assign chain_capture = out_ctl.capture;
  assign chain_latch   = out_ctl.latch;

endmodule

// File: tb/test_scanchain_refresh_ctrl.sv
`timescale 1ns/1ps
module test_scanchain_refresh_ctrl;

  localparam int ND   = 4;
  localparam int DW   = 8;
  localparam int SW   = 9;
  localparam int L    = ND * DW;
  localparam int P    = 2 * L + 4;
  localparam int NREF = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [SW-1:0] t_sel = '0;
  logic [DW-1:0] t_din = '0;
  logic [1:0]    t_mode = 2'b10;
  logic          t_div = 1'b0;
  logic ext_clk = 0, ext_data = 0, ext_capture = 0, ext_latch = 0;
  logic probe_clk = 0, probe_data = 0, probe_capture = 0, probe_latch = 0;
  logic tail = 1'b0;
  logic chain_clk, chain_data, chain_capture, chain_latch, refresh_done, tick_clk;
  logic [DW-1:0] dout;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  scanchain_refresh_ctrl #(.NUM_DESIGNS(ND), .DW(DW), .SEL_W(SW)) i_scanchain_refresh_ctrl (
    .clk(clk), .rst_n(rst_n), .target_idx(t_sel), .din(t_din), .drive_mode(t_mode),
    .div_enable(t_div), .ext_clk(ext_clk), .ext_data(ext_data), .ext_capture(ext_capture),
    .ext_latch(ext_latch), .probe_clk(probe_clk), .probe_data(probe_data),
    .probe_capture(probe_capture), .probe_latch(probe_latch), .chain_tail(tail),
    .chain_clk(chain_clk), .chain_data(chain_data), .chain_capture(chain_capture),
    .chain_latch(chain_latch), .dout(dout), .refresh_done(refresh_done), .tick_clk(tick_clk)
  );

  // chain model and reference state
  logic [L-1:0]  cpos = '0;
  logic [DW-1:0] cin [ND];
  logic [DW-1:0] written [ND];
  logic prev_clk = 0, prev_latch = 0;
  logic m_tick = 0, m_en_prev = 0;
  int   m_cnt = 0, m_div = 0;
  logic [SW-1:0] cur_sel;
  logic [DW-1:0] cur_wr, exp_dout;

  function automatic logic [DW-1:0] pat(int k);
    return 8'h3C ^ 8'(k * 37);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic apply_stim(int r);
    t_mode = (r >= 20 && r < 30) ? 2'b11 : 2'b10;
    if (r < 8) begin
      t_sel = SW'((r / 2) % ND); t_din = 8'hA5 ^ 8'(r * 29); t_div = 0;
    end else if (r == 8) begin
      t_sel = 9'd7; t_din = 8'hFF; t_div = 0;
    end else if (r == 9) begin
      t_sel = 9'd2; t_din = 8'h5E; t_div = 0;
    end else if (r == 10) begin
      t_sel = 9'd300; t_din = 8'h81; t_div = 0;
    end else if (r < 23) begin
      t_sel = 9'd1; t_din = (r == 11) ? 8'h00 : 8'(r * 13); t_div = 1;
    end else if (r == 23) begin
      t_sel = 9'd3; t_din = 8'h77; t_div = 0;
    end else if (r < 36) begin
      t_sel = SW'(r % ND); t_din = (r == 24) ? 8'h02 : 8'(r * 7 + 1); t_div = 1;
    end else begin
      t_sel = SW'((r * 3) % ND); t_din = 8'(r * 11); t_div = 0;
    end
  endtask

  task automatic chain_step();
    logic [DW-1:0] o;
    if (chain_clk && !prev_clk) begin
      if (chain_capture) begin
        for (int k = 0; k < ND; k++) begin
          o = cin[k] ^ pat(k);
          for (int b = 0; b < DW; b++) cpos[k*DW+b] = o[b];
        end
      end else begin
        cpos = {chain_data, cpos[L-1:1]};
      end
    end
    if (chain_latch && !prev_latch)
      for (int k = 0; k < ND; k++) cin[k] = cpos[k*DW +: DW];
    prev_clk = chain_clk;
    prev_latch = chain_latch;
    tail = cpos[0];
  endtask

  initial begin
    int n, r, phase;
    bit rdy;
    logic tick_at;
    for (int k = 0; k < ND; k++) begin cin[k] = '0; written[k] = '0; end
    apply_stim(0);
    cur_sel = t_sel; cur_wr = t_din; exp_dout = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11: reset state of outputs
    chk(!chain_clk && !chain_data && !chain_capture && !chain_latch, "R11 chain", 
        {chain_clk, chain_data, chain_capture, chain_latch}, 0);
    chk(dout == 0 && !refresh_done && !tick_clk, "R11 outputs", {dout, refresh_done, tick_clk}, 0);
    rst_n = 1'b1;
    n = 0; r = 0;
    while (r < NREF) begin
      @(negedge clk);
      chain_step();
      n++;
      phase = (n - 1) % P;
      rdy = (phase == P - 1);
      // tick reference (R8, R9)
      if (!t_div) begin m_tick = 0; m_cnt = 0; end
      else if (!m_en_prev) begin m_div = int'(t_din); m_cnt = 0; end
      else if (rdy) begin
        if (m_cnt == m_div) begin m_cnt = 0; m_tick = ~m_tick; end
        else m_cnt++;
      end
      m_en_prev = t_div;
      if (rdy) exp_dout = (cur_sel < ND) ? (written[cur_sel] ^ pat(int'(cur_sel))) : '0;
      // R1 timing
      chk(refresh_done == rdy, "R1/R4 refresh_done", refresh_done, rdy);
      chk(chain_capture == (phase < 2), "R1 capture", chain_capture, phase < 2);
      chk(chain_clk == ((phase % 2 == 1) && phase < 2*L+2), "R1 clock", chain_clk,
          (phase % 2 == 1) && phase < 2*L+2);
      chk(chain_latch == (phase == 2*L+2), "R1 latch", chain_latch, phase == 2*L+2);
      // R3/R4/R6 readback, R9 tick
      chk(dout == exp_dout, (cur_sel < ND) ? "R3/R4 dout" : "R6 dout", dout, exp_dout);
      chk(tick_clk == m_tick, "R8/R9 tick", tick_clk, m_tick);
      // R5: disturb inputs mid-refresh
      if (phase == 10 && (r % 2 == 1)) begin t_sel = ~t_sel; t_din = ~t_din; end
      if (rdy) begin
        for (int k = 0; k < ND; k++) written[k] = (cur_sel == SW'(k)) ? cur_wr : '0;
        for (int k = 0; k < ND; k++)
          chk(cin[k] == written[k], (cur_sel < ND) ? "R2/R5/R10 write" : "R6 write",
              cin[k], written[k]);
        r++;
        apply_stim(r);
        tick_at = m_tick;
        cur_sel = t_sel;
        cur_wr  = {t_din[DW-1:1], t_div ? tick_at : t_din[0]};
      end
    end
    // R7: external and probe drive selection
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      t_mode = 2'b00;
      {ext_clk, ext_data, ext_capture, ext_latch} = 4'(i);
      {probe_clk, probe_data, probe_capture, probe_latch} = ~4'(i);
      #1;
      chk({chain_clk, chain_data, chain_capture, chain_latch} == 4'(i), "R7 external",
          {chain_clk, chain_data, chain_capture, chain_latch}, i);
      t_mode = 2'b01;
      #1;
      chk({chain_clk, chain_data, chain_capture, chain_latch} == ~4'(i), "R7 probe",
          {chain_clk, chain_data, chain_capture, chain_latch}, ~4'(i));
    end
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule